// File: doc/BRIEF.md
# Register Write-Pending Scoreboard

This block keeps one pending-write bit for every architectural register so that a read-after-write hazard is found before any operand is fetched. Each function-unit write slot marks its destination register pending in the cycle it issues. The bit falls again when the register file grants a writeback to that register. It also falls when the owning unit finishes without producing a result, except for load/store slots, which are assumed always to write. Each read slot presents the register it wants and gets back a hazard flag. That flag suppresses the slot's read request toward the register-file port arbiter. A global hazard output summarises all read slots.

Register numbers are either binary-coded (the selection mask is a one shifted left by the number) or already one-hot (the number is the mask), chosen by the `ONEHOT` parameter.

Two small state machines per slot drive the logic. Each write slot has `WS_IDLE` and `WS_ARMED`, and `WS_ARMED` is its latched write flag. The write slot moves from `WS_IDLE` to `WS_ARMED` on an issue with the write flag set. From `WS_ARMED` it re-arms or drops on a new issue, according to that issue's flag, and it returns to `WS_IDLE` whenever its unit is not busy and not issuing. Each read slot has `RS_WATCH` and `RS_QUIET`. It moves from `RS_WATCH` to `RS_QUIET` when its unit is busy and no hazard is reported, and from `RS_QUIET` back to `RS_WATCH` once the unit is no longer busy.

Top module: `sb_scoreboard`

## Requirements
- R1: A synchronous reset clears every pending bit, every write-slot latch (state `WS_IDLE`) and every read slot (state `RS_WATCH`); after reset `pending_o` is zero and no hazard is reported.
- R2: When a write slot issues with its write flag high, the bit of its live destination register is set and visible on `pending_o` from the next cycle; an issue with the flag low sets nothing.
- R3: A granted writeback (`wb_en_i` high) clears the bit of `wb_reg_i` from the next cycle.
- R4: If one bit is set by an issue and cleared by a writeback in the same cycle, the set wins and the bit stays pending.
- R5: A write slot in `WS_ARMED` whose unit signals done with its result-valid flag low clears the pending bit of its latched destination from the next cycle; with the result-valid flag high, done clears nothing.
- R6: A write slot drops its latched flag (returns to `WS_IDLE`) in the cycle after its unit is seen not busy while not issuing; a later done without result then clears nothing.
- R7: Slots marked as load/store in `LS_MASK` never perform the done-without-result clear.
- R8: A read slot in `RS_WATCH` with `rd_active_i` high reports a hazard exactly when the pending bit of `rd_reg_i` is set; a slot with `rd_active_i` low reports none; `rd_req_o` equals `rd_req_i` with any hazarded slot's request removed.
- R9: A read slot whose unit is busy while reporting no hazard enters `RS_QUIET` and reports no hazard until the cycle after its busy input falls; a busy slot that is reporting a hazard keeps checking.
- R10: With `ONEHOT` set, register numbers are `NREG`-bit one-hot masks used directly; with it clear they are binary and bit n of the mask is register n.
- R11: `any_hazard_o` is high exactly when some pending bit is selected by the check mask of any read slot, so it is high whenever any `rd_hazard_o` bit is high.
- R12: The destination register is captured in the issue cycle; later changes of the live destination input do not change which bit a done-without-result clear affects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_issue_i | input | NW | Issue strobe per write slot |
| wr_flag_i | input | NW | Slot's instruction writes a register |
| wr_reg_i | input | NW x AW | Live decoded destination register per write slot |
| wr_busy_i | input | NW | Unit of the slot is busy |
| wr_done_i | input | NW | Unit of the slot has finished |
| wr_ok_i | input | NW | Unit produced a result (result-valid) |
| wb_en_i | input | 1 | Writeback granted on the register-file write port |
| wb_reg_i | input | AW | Register written by the granted writeback |
| rd_active_i | input | NR | Read slot is issuing and needs this register |
| rd_reg_i | input | NR x AW | Register number per read slot |
| rd_busy_i | input | NR | Unit of the read slot is busy |
| rd_req_i | input | NR | Raw read-port request per read slot |
| rd_req_o | output | NR | Read request with hazarded slots removed |
| rd_hazard_o | output | NR | Hazard flag per read slot |
| any_hazard_o | output | 1 | Some read slot's checked register is pending |
| pending_o | output | NREG | Pending-write bit per register |

## Verification
The bench aims at a clear and a set landing on the same bit in one cycle; a design that ordered them the other way would lose a freshly issued write and let a dependent read through. It moves the live destination input away after issue and then signals done without a result; a design that used the live number would clear the wrong bit and leave the real one stuck. It drops busy before a late done, and it sends done without a result to a load/store slot; a design that kept a stale latch, or ignored the load/store marking, would clear a bit that still has a write coming. It also parks a read slot in its quiet state while the register it watches becomes pending, which exposes a slot that never stops checking or never resumes.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // write-slot latched write flag
    typedef enum logic {
        WS_IDLE  = 1'b0,
        WS_ARMED = 1'b1
    } wslot_state_e;

    // read-slot checking phase
    typedef enum logic {
        RS_WATCH = 1'b0,
        RS_QUIET = 1'b1
    } rslot_state_e;

endpackage

// File: rtl/sb_regsel.sv
module sb_regsel #(
    parameter int NREG   = 32,
    parameter bit ONEHOT = 1'b0,
    localparam int AW    = ONEHOT ? NREG : $clog2(NREG)
) (
    input  logic [AW-1:0]   reg_i,
    output logic [NREG-1:0] mask_o
);

    generate
        if (ONEHOT) begin : g_onehot
            // register number is already a selection mask
            assign mask_o = reg_i;
        end else begin : g_binary
            assign mask_o = NREG'(1) << reg_i;
        end
    endgenerate

endmodule

// File: rtl/sb_wslot.sv
module sb_wslot
    import sb_pkg::*;
#(
    parameter int NREG   = 32,
    parameter bit ONEHOT = 1'b0,
    parameter bit IS_LS  = 1'b0,
    localparam int AW    = ONEHOT ? NREG : $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_i,
    input  logic            flag_i,
    input  logic [AW-1:0]   reg_i,
    input  logic            busy_i,
    input  logic            done_i,
    input  logic            ok_i,
    output logic [NREG-1:0] set_o,
    output logic [NREG-1:0] clr_o
);

    wslot_state_e    state_q, state_d;
    logic [AW-1:0]   dest_q;
    logic [AW-1:0]   dest_eff;
    logic [NREG-1:0] dest_mask;

    // destination captured on issue, live value passed through that cycle
    always_ff @(posedge clk) begin
        if (rst)          dest_q <= '0;
        else if (issue_i) dest_q <= reg_i;
    end

    assign dest_eff = issue_i ? reg_i : dest_q;

    sb_regsel #(.NREG(NREG), .ONEHOT(ONEHOT)) u_dsel (
        .reg_i  (dest_eff),
        .mask_o (dest_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= WS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        set_o   = '0;
        clr_o   = '0;
        if (issue_i && flag_i) set_o = dest_mask;
        unique case (state_q)
            WS_IDLE: begin
                if (issue_i && flag_i) state_d = WS_ARMED;
            end
            WS_ARMED: begin
                // finished with no result: the write never arrives
                if (!issue_i && done_i && !ok_i && !IS_LS) clr_o = dest_mask;
                if (issue_i)      state_d = flag_i ? WS_ARMED : WS_IDLE;
                else if (!busy_i) state_d = WS_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/sb_rslot.sv
module sb_rslot
    import sb_pkg::*;
#(
    parameter int NREG   = 32,
    parameter bit ONEHOT = 1'b0,
    localparam int AW    = ONEHOT ? NREG : $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active_i,
    input  logic [AW-1:0]   reg_i,
    input  logic            busy_i,
    input  logic            req_i,
    input  logic [NREG-1:0] vec_i,
    output logic [NREG-1:0] chk_o,
    output logic            hazard_o,
    output logic            req_o
);

    rslot_state_e    state_q, state_d;
    logic [NREG-1:0] sel_mask;

    sb_regsel #(.NREG(NREG), .ONEHOT(ONEHOT)) u_rsel (
        .reg_i  (reg_i),
        .mask_o (sel_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= RS_WATCH;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        chk_o    = '0;
        hazard_o = 1'b0;
        unique case (state_q)
            RS_WATCH: begin
                chk_o    = active_i ? sel_mask : '0;
                hazard_o = |(vec_i & chk_o);
                if (busy_i && !hazard_o) state_d = RS_QUIET;
            end
            RS_QUIET: begin
                if (!busy_i) state_d = RS_WATCH;
            end
        endcase
        req_o = req_i && !hazard_o;
    end

endmodule

// File: rtl/sb_vec.sv
module sb_vec #(
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] set_i,
    input  logic [NREG-1:0] clr_i,
    input  logic [NREG-1:0] chk_i,
    output logic [NREG-1:0] vec_o,
    output logic            any_o
);

    logic [NREG-1:0] vec_q;

    // set has priority over clear on the same bit
    always_ff @(posedge clk) begin
        if (rst) vec_q <= '0;
        else     vec_q <= (vec_q & ~clr_i) | set_i;
    end

    assign vec_o = vec_q;
    assign any_o = |(vec_q & chk_i);

endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
    parameter int            NREG    = 32,
    parameter bit            ONEHOT  = 1'b0,
    parameter int            NW      = 4,
    parameter int            NR      = 6,
    parameter logic [NW-1:0] LS_MASK = '0,
    localparam int           AW      = ONEHOT ? NREG : $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NW-1:0]          wr_issue_i,
    input  logic [NW-1:0]          wr_flag_i,
    input  logic [NW-1:0][AW-1:0]  wr_reg_i,
    input  logic [NW-1:0]          wr_busy_i,
    input  logic [NW-1:0]          wr_done_i,
    input  logic [NW-1:0]          wr_ok_i,
    input  logic                   wb_en_i,
    input  logic [AW-1:0]          wb_reg_i,
    input  logic [NR-1:0]          rd_active_i,
    input  logic [NR-1:0][AW-1:0]  rd_reg_i,
    input  logic [NR-1:0]          rd_busy_i,
    input  logic [NR-1:0]          rd_req_i,
    output logic [NR-1:0]          rd_req_o,
    output logic [NR-1:0]          rd_hazard_o,
    output logic                   any_hazard_o,
    output logic [NREG-1:0]        pending_o
);

    logic [NW-1:0][NREG-1:0] w_set;
    logic [NW-1:0][NREG-1:0] w_clr;
    logic [NR-1:0][NREG-1:0] r_chk;
    logic [NREG-1:0]         wb_mask;
    logic [NREG-1:0]         set_all;
    logic [NREG-1:0]         clr_all;
    logic [NREG-1:0]         chk_all;

    generate
        for (genvar w = 0; w < NW; w++) begin : g_wslot
            sb_wslot #(
                .NREG   (NREG),
                .ONEHOT (ONEHOT),
                .IS_LS  (LS_MASK[w])
            ) u_wslot (
                .clk     (clk),
                .rst     (rst),
                .issue_i (wr_issue_i[w]),
                .flag_i  (wr_flag_i[w]),
                .reg_i   (wr_reg_i[w]),
                .busy_i  (wr_busy_i[w]),
                .done_i  (wr_done_i[w]),
                .ok_i    (wr_ok_i[w]),
                .set_o   (w_set[w]),
                .clr_o   (w_clr[w])
            );
        end

        for (genvar r = 0; r < NR; r++) begin : g_rslot
            sb_rslot #(
                .NREG   (NREG),
                .ONEHOT (ONEHOT)
            ) u_rslot (
                .clk      (clk),
                .rst      (rst),
                .active_i (rd_active_i[r]),
                .reg_i    (rd_reg_i[r]),
                .busy_i   (rd_busy_i[r]),
                .req_i    (rd_req_i[r]),
                .vec_i    (pending_o),
                .chk_o    (r_chk[r]),
                .hazard_o (rd_hazard_o[r]),
                .req_o    (rd_req_o[r])
            );
        end
    endgenerate

    sb_regsel #(.NREG(NREG), .ONEHOT(ONEHOT)) u_wbsel (
        .reg_i  (wb_reg_i),
        .mask_o (wb_mask)
    );

    // OR-reduce the per-slot enables onto one set, one clear, one check port
    always_comb begin
        set_all = '0;
        clr_all = wb_en_i ? wb_mask : '0;
        chk_all = '0;
        for (int w = 0; w < NW; w++) begin
            set_all = set_all | w_set[w];
            clr_all = clr_all | w_clr[w];
        end
        for (int r = 0; r < NR; r++) begin
            chk_all = chk_all | r_chk[r];
        end
    end

    sb_vec #(.NREG(NREG)) u_vec (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_all),
        .clr_i (clr_all),
        .chk_i (chk_all),
        .vec_o (pending_o),
        .any_o (any_hazard_o)
    );

endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
    parameter int  NREG   = 32,
    parameter bit  ONEHOT = 1'b0,
    parameter int  NW     = 4,
    parameter int  NR     = 6,
    localparam int AW     = ONEHOT ? NREG : $clog2(NREG)
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NW-1:0]         wr_issue_i,
    input logic [NW-1:0]         wr_flag_i,
    input logic [NW-1:0][AW-1:0] wr_reg_i,
    input logic                  wb_en_i,
    input logic [AW-1:0]         wb_reg_i,
    input logic [NR-1:0]         rd_active_i,
    input logic [NR-1:0][AW-1:0] rd_reg_i,
    input logic [NR-1:0]         rd_req_i,
    input logic [NR-1:0]         rd_req_o,
    input logic [NR-1:0]         rd_hazard_o,
    input logic                  any_hazard_o,
    input logic [NREG-1:0]       pending_o
);

    logic [NW-1:0][NREG-1:0] wm;
    logic [NR-1:0][NREG-1:0] rm;
    logic [NREG-1:0]         wbm;
    logic [NREG-1:0]         issue_set;

    sb_regsel #(.NREG(NREG), .ONEHOT(ONEHOT)) u_cwb (.reg_i(wb_reg_i), .mask_o(wbm));

    always_comb begin
        issue_set = '0;
        for (int w = 0; w < NW; w++)
            if (wr_issue_i[w] && wr_flag_i[w]) issue_set = issue_set | wm[w];
    end

    // R1: reset leaves nothing pending and no hazard
    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (pending_o == '0 && !any_hazard_o));

    // R3: granted writeback with no competing set clears the bit
    a_r3_wb_clears: assert property (@(posedge clk) disable iff (rst)
        (wb_en_i && ((issue_set & wbm) == '0)) |=> ((pending_o & $past(wbm)) == '0));

    // R11: any slot hazard shows on the global output
    a_r11_any_covers: assert property (@(posedge clk) disable iff (rst)
        (|rd_hazard_o) |-> any_hazard_o);

    generate
        for (genvar w = 0; w < NW; w++) begin : g_wchk
            sb_regsel #(.NREG(NREG), .ONEHOT(ONEHOT)) u_cw (.reg_i(wr_reg_i[w]), .mask_o(wm[w]));

            // R2 and R4: an issue with the write flag always leaves the bit set
            a_r2_issue_sets: assert property (@(posedge clk) disable iff (rst)
                (wr_issue_i[w] && wr_flag_i[w]) |=>
                    ((pending_o & $past(wm[w])) == $past(wm[w])));
        end

        for (genvar r = 0; r < NR; r++) begin : g_rchk
            sb_regsel #(.NREG(NREG), .ONEHOT(ONEHOT)) u_cr (.reg_i(rd_reg_i[r]), .mask_o(rm[r]));

            // R8: only an active slot with a pending register is hazarded
            a_r8_hazard_needs_active: assert property (@(posedge clk) disable iff (rst)
                rd_hazard_o[r] |-> (rd_active_i[r] && ((pending_o & rm[r]) != '0)));

            // R8: a forwarded request always comes from a raw request
            a_r8_req_from_raw: assert property (@(posedge clk) disable iff (rst)
                rd_req_o[r] |-> rd_req_i[r]);
        end
    endgenerate

endmodule

bind sb_scoreboard sb_scoreboard_chk #(
    .NREG   (NREG),
    .ONEHOT (ONEHOT),
    .NW     (NW),
    .NR     (NR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_issue_i   (wr_issue_i),
    .wr_flag_i    (wr_flag_i),
    .wr_reg_i     (wr_reg_i),
    .wb_en_i      (wb_en_i),
    .wb_reg_i     (wb_reg_i),
    .rd_active_i  (rd_active_i),
    .rd_reg_i     (rd_reg_i),
    .rd_req_i     (rd_req_i),
    .rd_req_o     (rd_req_o),
    .rd_hazard_o  (rd_hazard_o),
    .any_hazard_o (any_hazard_o),
    .pending_o    (pending_o)
);

// File: tb/sb_scoreboard_test.sv
module sb_scoreboard_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 4 ns period, 250 MHz

    // main instance: 8 registers binary, 2 write slots (slot 1 load/store), 2 read slots
    logic [1:0]      wr_issue = '0, wr_flag = '0, wr_busy = '0, wr_done = '0, wr_ok = '0;
    logic [1:0][2:0] wr_reg = '0;
    logic            wb_en = 1'b0;
    logic [2:0]      wb_reg = '0;
    logic [1:0]      rd_active = '0, rd_busy = '0, rd_req = '0;
    logic [1:0][2:0] rd_reg = '0;
    logic [1:0]      rd_req_o, rd_haz;
    logic            any_haz;
    logic [7:0]      pend;

    sb_scoreboard #(.NREG(8), .ONEHOT(1'b0), .NW(2), .NR(2), .LS_MASK(2'b10)) uut (
        .clk(clk), .rst(rst),
        .wr_issue_i(wr_issue), .wr_flag_i(wr_flag), .wr_reg_i(wr_reg),
        .wr_busy_i(wr_busy), .wr_done_i(wr_done), .wr_ok_i(wr_ok),
        .wb_en_i(wb_en), .wb_reg_i(wb_reg),
        .rd_active_i(rd_active), .rd_reg_i(rd_reg), .rd_busy_i(rd_busy), .rd_req_i(rd_req),
        .rd_req_o(rd_req_o), .rd_hazard_o(rd_haz), .any_hazard_o(any_haz), .pending_o(pend)
    );

    // one-hot instance: 4 registers, 1 write slot, 1 read slot
    logic       oh_issue = 1'b0, oh_flag = 1'b0, oh_act = 1'b0;
    logic [3:0] oh_wreg = '0, oh_rreg = '0;
    logic [0:0] oh_req_o, oh_haz;
    logic       oh_any;
    logic [3:0] oh_pend;

    sb_scoreboard #(.NREG(4), .ONEHOT(1'b1), .NW(1), .NR(1), .LS_MASK(1'b0)) uut_oh (
        .clk(clk), .rst(rst),
        .wr_issue_i(oh_issue), .wr_flag_i(oh_flag), .wr_reg_i(oh_wreg),
        .wr_busy_i(1'b0), .wr_done_i(1'b0), .wr_ok_i(1'b0),
        .wb_en_i(1'b0), .wb_reg_i(4'b0000),
        .rd_active_i(oh_act), .rd_reg_i(oh_rreg), .rd_busy_i(1'b0), .rd_req_i(1'b0),
        .rd_req_o(oh_req_o), .rd_hazard_o(oh_haz), .any_hazard_o(oh_any), .pending_o(oh_pend)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done_run = 1'b0;

    typedef struct {
        int         at;
        logic [7:0] pend;
        logic [1:0] haz;
        logic       any;
        logic [1:0] reqo;
        string      tag;
    } exp_t;

    exp_t q[$];

    always @(posedge clk) cyc = cyc + 1;

    task automatic cmp(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // driver side: expected outputs for the current cycle
    task automatic expect_now(input logic [7:0] p, input logic [1:0] h, input logic a,
                              input logic [1:0] ro, input string tag);
        exp_t e;
        e.at = cyc; e.pend = p; e.haz = h; e.any = a; e.reqo = ro; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare between edges, after the driver has settled inputs
    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "pending", pend, e.pend);
            cmp(e.tag, "rd_hazard", {6'b0, rd_haz}, {6'b0, e.haz});
            cmp(e.tag, "any_hazard", {7'b0, any_haz}, {7'b0, e.any});
            cmp(e.tag, "rd_req_o", {6'b0, rd_req_o}, {6'b0, e.reqo});
        end
    end

    task automatic step();
        @(negedge clk);
        wr_issue = '0; wr_done = '0; wb_en = 1'b0; rd_req = '0;
        oh_issue = 1'b0;
    endtask

    initial begin
        step(); step();
        step(); rst = 1'b0;
        expect_now(8'h00, 2'b00, 1'b0, 2'b00, "R1 reset state");

        // slot 0 writes r3
        step(); wr_issue[0] = 1'b1; wr_flag[0] = 1'b1; wr_reg[0] = 3'd3;
        rd_active[0] = 1'b1; rd_reg[0] = 3'd3;
        expect_now(8'h00, 2'b00, 1'b0, 2'b00, "R2 not set during issue cycle");
        step(); wr_busy[0] = 1'b1; wr_reg[0] = 3'd5; rd_req[0] = 1'b1;
        expect_now(8'h08, 2'b01, 1'b1, 2'b00, "R8 R2 hazard on r3 blocks request");
        step(); wr_done[0] = 1'b1; wr_ok[0] = 1'b1; rd_reg[0] = 3'd5; rd_req[0] = 1'b1;
        expect_now(8'h08, 2'b00, 1'b0, 2'b01, "R8 R12 no hazard on r5, request passes");
        step(); wr_done[0] = 1'b1; wr_ok[0] = 1'b0; rd_active[0] = 1'b0;
        expect_now(8'h08, 2'b00, 1'b0, 2'b00, "R5 done with result keeps bit");
        step(); wr_busy[0] = 1'b0;
        expect_now(8'h00, 2'b00, 1'b0, 2'b00, "R5 R12 no-result done clears latched r3");

        // issue without write flag, then with flag and no busy
        step(); wr_issue[0] = 1'b1; wr_flag[0] = 1'b0; wr_reg[0] = 3'd2;
        expect_now(8'h00, 2'b00, 1'b0, 2'b00, "R2 issue cycle");
        step(); wr_issue[0] = 1'b1; wr_flag[0] = 1'b1; wr_reg[0] = 3'd4;
        expect_now(8'h00, 2'b00, 1'b0, 2'b00, "R2 flag low sets nothing");
        step();
        expect_now(8'h10, 2'b00, 1'b0, 2'b00, "R2 r4 set");
        step(); wr_done[0] = 1'b1; wr_ok[0] = 1'b0;
        expect_now(8'h10, 2'b00, 1'b0, 2'b00, "R6 latch dropped after idle");
        step(); wb_en = 1'b1; wb_reg = 3'd4;
        expect_now(8'h10, 2'b00, 1'b0, 2'b00, "R6 late done cleared nothing");

        // load/store slot 1
        step(); wr_issue[1] = 1'b1; wr_flag[1] = 1'b1; wr_reg[1] = 3'd1;
        expect_now(8'h00, 2'b00, 1'b0, 2'b00, "R3 writeback cleared r4");
        step(); wr_busy[1] = 1'b1;
        expect_now(8'h02, 2'b00, 1'b0, 2'b00, "R2 r1 set by slot 1");
        step(); wr_done[1] = 1'b1; wr_ok[1] = 1'b0;
        expect_now(8'h02, 2'b00, 1'b0, 2'b00, "R7 before load/store done");
        step(); wr_issue[1] = 1'b1; wr_flag[1] = 1'b1; wr_reg[1] = 3'd6;
        wb_en = 1'b1; wb_reg = 3'd6;
        expect_now(8'h02, 2'b00, 1'b0, 2'b00, "R7 load/store done kept r1");
        step(); wb_en = 1'b1; wb_reg = 3'd1;
        expect_now(8'h42, 2'b00, 1'b0, 2'b00, "R4 set beats clear on r6");

        // read slot 1 quiet phase
        step(); rd_active[1] = 1'b1; rd_reg[1] = 3'd2; rd_busy[1] = 1'b1;
        expect_now(8'h40, 2'b00, 1'b0, 2'b00, "R3 r1 cleared");
        step(); rd_reg[1] = 3'd6;
        expect_now(8'h40, 2'b00, 1'b0, 2'b00, "R9 quiet slot ignores pending r6");
        step(); rd_busy[1] = 1'b0;
        expect_now(8'h40, 2'b00, 1'b0, 2'b00, "R9 quiet in busy-drop cycle");
        step(); rd_active[0] = 1'b1; rd_reg[0] = 3'd6;
        expect_now(8'h40, 2'b11, 1'b1, 2'b00, "R9 R11 checking resumed");
        step(); rd_busy[1] = 1'b1; rd_req = 2'b11;
        expect_now(8'h40, 2'b11, 1'b1, 2'b00, "R9 busy with hazard keeps checking");
        step(); rd_req = 2'b10;
        expect_now(8'h40, 2'b11, 1'b1, 2'b00, "R9 R8 hazard persists");
        step(); rd_active = 2'b00; rd_busy[1] = 1'b0; rd_req = 2'b11;
        wr_issue[0] = 1'b1; wr_flag[0] = 1'b1; wr_reg[0] = 3'd0;
        expect_now(8'h40, 2'b00, 1'b0, 2'b11, "R8 inactive slots pass requests");
        step(); rst = 1'b1;
        expect_now(8'h41, 2'b00, 1'b0, 2'b00, "R2 r0 set");
        step(); rst = 1'b0; rd_active[1] = 1'b1; rd_reg[1] = 3'd0;
        expect_now(8'h00, 2'b00, 1'b0, 2'b00, "R1 reset mid-run clears all");
        step();
        expect_now(8'h00, 2'b00, 1'b0, 2'b00, "R1 stays clear");

        // one-hot variant
        step(); oh_issue = 1'b1; oh_flag = 1'b1; oh_wreg = 4'b0100;
        oh_act = 1'b1; oh_rreg = 4'b0100;
        step();
        #1;
        cmp("R10 one-hot", "pending", {4'b0, oh_pend}, 8'h04);
        cmp("R10 one-hot", "rd_hazard", {7'b0, oh_haz[0]}, 8'h01);
        cmp("R10 one-hot", "any_hazard", {7'b0, oh_any}, 8'h01);
        oh_rreg = 4'b0010;
        #1;
        cmp("R10 one-hot other reg", "rd_hazard", {7'b0, oh_haz[0]}, 8'h00);

        step(); step();
        done_run = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule